// File: doc/BRIEF.md
# Output Compare Pin Action Unit

This block turns output-compare events into activity on eight timer port pins. Each channel receives a one-cycle match pulse from an external comparator, where a free-running counter is compared with that channel's compare value. On a match, the unit applies the channel's programmed pin action to the port latch and raises the channel's interrupt flag. All of this happens on the clock edge that samples the pulse.

Software can also fire a channel's pin action directly through a force register. A forced event behaves like a match except that no flag is raised. Channel 7 has a special role. It owns a mask and a data register. When channel 7 fires, every port bit selected by the mask is loaded from the data register. A masked bit also ignores its own channel's action. If a masked pin is configured for output compare, its output driver is switched on whatever its direction bit holds.

Registers are reached over a plain bus: address, write data, write strobe and combinational read data. The counter, its prescaler, input capture and interrupt routing sit outside this block.

Top module: `ocp_unit`

## Requirements
- R1: After synchronous reset, all registers read 0, `pin_out` is 0 and `pin_oe` is 0.
- R2: Each channel has a 2-bit action code: 00 does nothing, 01 toggles the pin, 10 drives it low, 11 drives it high. Channels 0-3 use the register at address 3 and channels 4-7 use address 4, with channel k at bits [2k+1:2k] of its half. The action is applied on the edge that samples the channel's match only if the channel's compare-select bit is 1 (address 5).
- R3: A match sets that channel's flag (address 7) on the same edge. Writing 1 to a flag bit clears it. A match in the same cycle as a clear leaves the flag set.
- R4: Writing a 1 to bit n of the force register (address 0) applies channel n's action on that write's edge and leaves the flags unchanged.
- R5: The force register always reads 0.
- R6: A force and a match on the same channel in the same cycle apply the action once (a toggle flips the pin once), and the flag is set.
- R7: On a channel-7 match or force, each port bit whose channel-7 mask bit (address 1) is 1 is loaded from the matching bit of the channel-7 data register (address 2).
- R8: A port bit whose mask bit is 1 is not changed by its own channel's action.
- R9: `pin_oe[n]` is the direction bit (address 6) ORed with the compare-select bit ANDed with (mask bit OR action code not 00). The direction register keeps the value software wrote.
- R10: The mask, data, action halves, compare-select and direction registers read back the value last written.
- R11: A write to address 8 loads the port latch, except on bits that a mask load or a non-00 action changes in that cycle. Reading address 8 returns the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (4) | Register address |
| bus_wdata | input | N_CH (8) | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | N_CH (8) | Read data, combinational |
| cmp_match | input | N_CH (8) | Per-channel compare match pulse |
| pin_out | output | N_CH (8) | Port pin output values |
| pin_oe | output | N_CH (8) | Port pin output enables |

## Verification
On every cycle, the assertions check four things. The force address reads zero. A match always leaves its flag set. A force alone never changes the flags. A masked compare pin always has its driver enabled. They also check two channel-7 rules: a channel-7 event loads the masked bits from the data register, and masked bits hold still when no channel-7 event or port write occurs. The bench's scenarios are needed for the rest: the exact result of each action code, a force and a match landing together, the ordering between a port write and a pin action, and read-back of each register. A cycle-by-cycle model follows these.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } act_e;

    typedef struct packed {
        logic ocsel;
        logic mask;
        logic dir;
        act_e act;
    } pin_cfg_t;

    localparam int OCP_ADDR_FORCE  = 0;
    localparam int OCP_ADDR_MASK   = 1;
    localparam int OCP_ADDR_DATA   = 2;
    localparam int OCP_ADDR_ACT_LO = 3;
    localparam int OCP_ADDR_ACT_HI = 4;
    localparam int OCP_ADDR_OCSEL  = 5;
    localparam int OCP_ADDR_DIR    = 6;
    localparam int OCP_ADDR_FLAG   = 7;
    localparam int OCP_ADDR_PORT   = 8;

    function automatic logic apply_act(act_e a, logic cur);
        case (a)
            ACT_TOGGLE: return ~cur;
            ACT_CLEAR:  return 1'b0;
            ACT_SET:    return 1'b1;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/ocp_regs.sv
module ocp_regs
    import ocp_pkg::*;
#(
    parameter int N_CH = 8,
    parameter int AW   = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [AW-1:0]         bus_addr,
    input  logic [N_CH-1:0]       bus_wdata,
    input  logic                  bus_wr,
    input  logic [N_CH-1:0]       cmp_match,
    input  logic [N_CH-1:0]       port_val,
    output pin_cfg_t [N_CH-1:0]   cfg,
    output logic [N_CH-1:0]       c7_data,
    output logic [N_CH-1:0]       force_pulse,
    output logic                  port_wr,
    output logic [N_CH-1:0]       flags,
    output logic [N_CH-1:0]       bus_rdata
);
    localparam int HALF = N_CH / 2;
    localparam int ACTW = 2 * N_CH;

    logic [N_CH-1:0] mask_q, data_q, ocsel_q, dir_q, flag_q;
    logic [ACTW-1:0] act_q;
    logic [N_CH-1:0] flag_clr;

    function automatic logic hit(input logic [AW-1:0] a, input int code);
        return a == AW'(code);
    endfunction

    assign force_pulse = (bus_wr && hit(bus_addr, OCP_ADDR_FORCE)) ? bus_wdata : '0;
    assign port_wr     = bus_wr && hit(bus_addr, OCP_ADDR_PORT);
    assign flag_clr    = (bus_wr && hit(bus_addr, OCP_ADDR_FLAG)) ? bus_wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            data_q  <= '0;
            ocsel_q <= '0;
            dir_q   <= '0;
            act_q   <= '0;
            flag_q  <= '0;
        end else begin
            if (bus_wr) begin
                if (hit(bus_addr, OCP_ADDR_MASK))   mask_q  <= bus_wdata;
                if (hit(bus_addr, OCP_ADDR_DATA))   data_q  <= bus_wdata;
                if (hit(bus_addr, OCP_ADDR_OCSEL))  ocsel_q <= bus_wdata;
                if (hit(bus_addr, OCP_ADDR_DIR))    dir_q   <= bus_wdata;
                if (hit(bus_addr, OCP_ADDR_ACT_LO)) act_q[N_CH-1:0]    <= bus_wdata;
                if (hit(bus_addr, OCP_ADDR_ACT_HI)) act_q[ACTW-1:N_CH] <= bus_wdata;
            end
            // set has priority over a same-cycle clear
            flag_q <= (flag_q & ~flag_clr) | cmp_match;
        end
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_cfg
        assign cfg[i].ocsel = ocsel_q[i];
        assign cfg[i].mask  = mask_q[i];
        assign cfg[i].dir   = dir_q[i];
        assign cfg[i].act   = act_e'(act_q[2*i+1:2*i]);
    end

    assign c7_data = data_q;
    assign flags   = flag_q;

    always_comb begin
        bus_rdata = '0;
        if (hit(bus_addr, OCP_ADDR_MASK))   bus_rdata = mask_q;
        if (hit(bus_addr, OCP_ADDR_DATA))   bus_rdata = data_q;
        if (hit(bus_addr, OCP_ADDR_ACT_LO)) bus_rdata = act_q[N_CH-1:0];
        if (hit(bus_addr, OCP_ADDR_ACT_HI)) bus_rdata = act_q[ACTW-1:N_CH];
        if (hit(bus_addr, OCP_ADDR_OCSEL))  bus_rdata = ocsel_q;
        if (hit(bus_addr, OCP_ADDR_DIR))    bus_rdata = dir_q;
        if (hit(bus_addr, OCP_ADDR_FLAG))   bus_rdata = flag_q;
        if (hit(bus_addr, OCP_ADDR_PORT))   bus_rdata = port_val;
    end

    if (HALF * 2 != N_CH) begin : g_bad_width
        initial $error("N_CH must be even");
    end

endmodule

// File: rtl/ocp_pin_slice.sv
module ocp_pin_slice
    import ocp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_cfg_t cfg,
    input  logic     hit_own,
    input  logic     hit_c7,
    input  logic     c7_bit,
    input  logic     port_wr,
    input  logic     port_bit,
    output logic     pin,
    output logic     oe
);
    logic pin_q, pin_d;
    logic act_live;

    assign act_live = cfg.act != ACT_NONE;

    always_comb begin
        pin_d = pin_q;
        if (hit_c7 && cfg.mask)
            pin_d = c7_bit;
        else if (hit_own && cfg.ocsel && !cfg.mask && act_live)
            pin_d = apply_act(cfg.act, pin_q);
        else if (port_wr)
            pin_d = port_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b0;
        else     pin_q <= pin_d;
    end

    assign pin = pin_q;
    assign oe  = cfg.dir | (cfg.ocsel & (cfg.mask | act_live));

endmodule

// File: rtl/ocp_unit.sv
module ocp_unit
    import ocp_pkg::*;
#(
    parameter int N_CH = 8,
    parameter int AW   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic [N_CH-1:0] bus_wdata,
    input  logic            bus_wr,
    output logic [N_CH-1:0] bus_rdata,
    input  logic [N_CH-1:0] cmp_match,
    output logic [N_CH-1:0] pin_out,
    output logic [N_CH-1:0] pin_oe
);
    localparam int C7 = N_CH - 1;

    pin_cfg_t [N_CH-1:0] cfg;
    logic [N_CH-1:0] c7_data, c7_mask, ocsel_v, force_pulse, flags, hit;
    logic            port_wr;

    ocp_regs #(.N_CH(N_CH), .AW(AW)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_wr      (bus_wr),
        .cmp_match   (cmp_match),
        .port_val    (pin_out),
        .cfg         (cfg),
        .c7_data     (c7_data),
        .force_pulse (force_pulse),
        .port_wr     (port_wr),
        .flags       (flags),
        .bus_rdata   (bus_rdata)
    );

    // a forced event joins the real match so the action is applied once
    assign hit = cmp_match | force_pulse;

    for (genvar i = 0; i < N_CH; i++) begin : g_pin
        assign c7_mask[i] = cfg[i].mask;
        assign ocsel_v[i] = cfg[i].ocsel;

        ocp_pin_slice u_slice (
            .clk      (clk),
            .rst      (rst),
            .cfg      (cfg[i]),
            .hit_own  (hit[i]),
            .hit_c7   (hit[C7]),
            .c7_bit   (c7_data[i]),
            .port_wr  (port_wr),
            .port_bit (bus_wdata[i]),
            .pin      (pin_out[i]),
            .oe       (pin_oe[i])
        );
    end

endmodule

// File: rtl/ocp_unit_chk.sv
module ocp_unit_chk
    import ocp_pkg::*;
#(
    parameter int N_CH = 8,
    parameter int AW   = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [AW-1:0]   bus_addr,
    input logic [N_CH-1:0] bus_wdata,
    input logic            bus_wr,
    input logic [N_CH-1:0] bus_rdata,
    input logic [N_CH-1:0] cmp_match,
    input logic [N_CH-1:0] pin_out,
    input logic [N_CH-1:0] pin_oe,
    input logic [N_CH-1:0] c7_mask,
    input logic [N_CH-1:0] c7_data,
    input logic [N_CH-1:0] ocsel_v,
    input logic [N_CH-1:0] flags
);
    logic force_wr, port_wr, hit7;

    assign force_wr = bus_wr && (bus_addr == AW'(OCP_ADDR_FORCE));
    assign port_wr  = bus_wr && (bus_addr == AW'(OCP_ADDR_PORT));
    assign hit7     = cmp_match[N_CH-1] | (force_wr & bus_wdata[N_CH-1]);

    assert_force_reads_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == AW'(OCP_ADDR_FORCE)) |-> (bus_rdata == '0));

    assert_match_sets_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (cmp_match != '0) |=> ((flags & $past(cmp_match)) == $past(cmp_match)));

    assert_force_keeps_flags_R4: assert property (@(posedge clk) disable iff (rst)
        (force_wr && cmp_match == '0) |=> (flags == $past(flags)));

    assert_c7_load_R7: assert property (@(posedge clk) disable iff (rst)
        hit7 |=> (((pin_out ^ $past(c7_data)) & $past(c7_mask)) == '0));

    assert_masked_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!hit7 && !port_wr) |=> (((pin_out ^ $past(pin_out)) & $past(c7_mask)) == '0));

    assert_masked_oe_R9: assert property (@(posedge clk) disable iff (rst)
        ((c7_mask & ocsel_v & ~pin_oe) == '0));

endmodule

bind ocp_unit ocp_unit_chk #(.N_CH(N_CH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .cmp_match (cmp_match),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .c7_mask   (c7_mask),
    .c7_data   (c7_data),
    .ocsel_v   (ocsel_v),
    .flags     (flags)
);

// File: tb/tb_ocp_unit.sv
module tb_ocp_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] bus_addr;
    logic [7:0] bus_wdata;
    logic       bus_wr;
    logic [7:0] bus_rdata;
    logic [7:0] cmp_match;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    int n_run  = 0;
    int n_fail = 0;

    // behavioural reference state
    logic [7:0]  m_mask, m_data, m_ocsel, m_dir, m_flags, m_port;
    logic [15:0] m_act;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocp_unit dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rdata(bus_rdata), .cmp_match(cmp_match),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int code_of(int ch);
        return int'((m_act >> (2*ch)) & 16'h3);
    endfunction

    function automatic logic [7:0] model_oe();
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = m_dir[i] | (m_ocsel[i] & (m_mask[i] | (code_of(i) != 0)));
        return r;
    endfunction

    function automatic logic [7:0] model_read(int a);
        case (a)
            1: return m_mask;
            2: return m_data;
            3: return m_act[7:0];
            4: return m_act[15:8];
            5: return m_ocsel;
            6: return m_dir;
            7: return m_flags;
            8: return m_port;
            default: return 8'h00;
        endcase
    endfunction

    // one clock: model next state, drive, compare both pin outputs after the edge
    task automatic step(bit wr, int a, logic [7:0] wd, logic [7:0] m, string tag);
        logic [7:0] frc, ev, nport, clr;
        int c;
        frc = (wr && a == 0) ? wd : 8'h00;
        ev  = m | frc;
        nport = m_port;
        for (int i = 0; i < 8; i++) begin
            c = code_of(i);
            if (ev[7] && m_mask[i])                          nport[i] = m_data[i];
            else if (ev[i] && m_ocsel[i] && !m_mask[i] && c != 0)
                nport[i] = (c == 1) ? ~m_port[i] : (c == 3);
            else if (wr && a == 8)                           nport[i] = wd[i];
        end
        clr = (wr && a == 7) ? wd : 8'h00;
        m_flags = (m_flags & ~clr) | m;
        m_port  = nport;
        if (wr) begin
            case (a)
                1: m_mask  = wd;
                2: m_data  = wd;
                3: m_act[7:0]  = wd;
                4: m_act[15:8] = wd;
                5: m_ocsel = wd;
                6: m_dir   = wd;
                default: ;
            endcase
        end
        bus_wr = wr; bus_addr = 4'(a); bus_wdata = wd; cmp_match = m;
        @(posedge clk);
        #1;
        chk({tag, " pin_out"}, pin_out, m_port);
        chk({tag, " pin_oe"},  pin_oe,  model_oe());
        @(negedge clk);
        bus_wr = 1'b0; cmp_match = 8'h00; bus_wdata = 8'h00;
    endtask

    task automatic rd(int a, string tag);
        bus_wr = 1'b0; bus_addr = 4'(a); cmp_match = 8'h00;
        #1;
        chk({tag, " read"}, bus_rdata, model_read(a));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        m_mask = 0; m_data = 0; m_ocsel = 0; m_dir = 0; m_flags = 0; m_port = 0; m_act = 0;
        rst = 1'b1; bus_wr = 1'b0; bus_addr = 4'd0; bus_wdata = 8'h00; cmp_match = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 pin_oe", pin_oe, 8'h00);
        for (int a = 0; a <= 8; a++) rd(a, "R1");

        // R10 register setup and read-back
        step(1, 1, 8'hF0, 8'h00, "R10");
        step(1, 2, 8'hA5, 8'h00, "R10");
        step(1, 3, 8'h39, 8'h00, "R10");   // ch0 toggle, ch1 clear, ch2 set, ch3 none
        step(1, 4, 8'h67, 8'h00, "R10");   // ch4 set, ch5 toggle, ch6 clear, ch7 toggle
        step(1, 5, 8'h0F, 8'h00, "R10");
        for (int a = 1; a <= 6; a++) rd(a, "R10");

        // R11 port write
        step(1, 8, 8'h06, 8'h00, "R11");
        rd(8, "R11");
        chk("R11 literal", pin_out, 8'h06);

        // R2 action codes
        step(0, 0, 8'h00, 8'h0F, "R2");
        chk("R2 literal", pin_out, 8'h05);
        step(0, 0, 8'h00, 8'h08, "R2 none");
        step(1, 5, 8'h0E, 8'h00, "R2");
        step(0, 0, 8'h00, 8'h01, "R2 unselected");
        chk("R2 unselected literal", pin_out, 8'h05);
        step(1, 5, 8'h0F, 8'h00, "R2");

        // R3 flags
        rd(7, "R3");
        step(1, 7, 8'h03, 8'h00, "R3");
        rd(7, "R3");
        step(1, 7, 8'h04, 8'h04, "R3 set-wins");
        rd(7, "R3");
        step(1, 7, 8'hFF, 8'h00, "R3");
        rd(7, "R3");

        // R4 / R5 force
        step(1, 0, 8'h01, 8'h00, "R4");
        chk("R4 literal", pin_out, 8'h04);
        rd(7, "R4");
        rd(0, "R5");

        // R6 force and match together
        step(1, 0, 8'h01, 8'h01, "R6");
        chk("R6 literal", pin_out, 8'h05);
        rd(7, "R6");

        // R11 port write against a live action
        step(1, 8, 8'hFF, 8'h02, "R11 vs action");
        chk("R11 literal", pin_out, 8'hFD);

        // R7 channel-7 transfer via match and via force
        step(1, 5, 8'hFF, 8'h00, "R7");
        step(0, 0, 8'h00, 8'h80, "R7 match");
        chk("R7 literal", pin_out & 8'hF0, 8'hA0);
        step(1, 2, 8'h5A, 8'h00, "R7");
        step(1, 0, 8'h80, 8'h00, "R7 force");
        chk("R7 literal", pin_out & 8'hF0, 8'h50);
        rd(7, "R7");

        // R8 mask priority
        step(0, 0, 8'h00, 8'h40, "R8 masked");
        chk("R8 literal", pin_out[6], 1'b1);
        step(1, 1, 8'h00, 8'h00, "R8");
        step(0, 0, 8'h00, 8'h40, "R8 unmasked");
        chk("R8 literal", pin_out[6], 1'b0);

        // R9 output enables
        step(1, 6, 8'h01, 8'h00, "R9");
        chk("R9 literal", pin_oe, 8'hF7);
        step(1, 5, 8'h00, 8'h00, "R9");
        chk("R9 literal", pin_oe, 8'h01);
        step(1, 1, 8'h08, 8'h00, "R9");
        step(1, 5, 8'h08, 8'h00, "R9");
        chk("R9 literal", pin_oe, 8'h09);
        rd(6, "R9");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule